// File: doc/BRIEF.md
# I2C Byte Shifter with Host-Paced Receive Buffer

This block is the byte-level data path of a host-driven I2C master. One data register address serves an 8-bit parallel host bus in both directions. Writes land in a shift register that drives SDA. Reads return a separate receive buffer, and never the shift register itself. The block generates SCL itself, with each half period lasting `HALF` clock cycles. Start and stop generation happen elsewhere. The block sees them only as a bus-busy level and a strobe that marks a finished start condition.

In transmit mode, a host write starts a byte at once, as long as serial output is enabled and a start has completed. In receive mode, the host controls the pace. A first, dummy read returns a stale value and starts the first byte. Each completed byte is copied into the buffer when the acknowledge bit begins. After that bit, SCL stays low until the host touches the data register. Accesses from the host must be spaced apart, and the block flags a not-ready window after each accepted access.

Top module: `i2c_byte_shifter`

## Requirements
- R1: A synchronous reset releases SDA and SCL, clears the pending flag, the not-ready flag and the receive buffer (read value 0x00).
- R2: Bytes leave the shift register most significant bit first, and the SDA drive changes only in a cycle where SCL is driven low.
- R3: A transmit byte starts only when a write has been accepted, `ser_en` is 1 and a start has completed (`start_done` pulsed while `bus_busy` is 1). A write made while `ser_en` is 0 waits and is sent once `ser_en` goes to 1.
- R4: In transmit mode, the level seen on SDA at the SCL rise of the ninth (acknowledge) bit is captured on `lrb`: 0 means acknowledged, 1 means not acknowledged.
- R5: A read returns the receive buffer, whatever was last written to the shift register. The first read after switching to receive returns the previous buffer value and starts reception of one byte.
- R6: In receive mode, the eight sampled bits are copied to the receive buffer, and `pend` is set to 1, when the acknowledge bit begins.
- R7: Once the acknowledge bit of a byte ends, SCL is held low with no further clock pulses while `pend` is 1. An accepted data-register access clears `pend`. In receive mode, only a read starts the next byte.
- R8: During the acknowledge bit of a received byte, SDA is driven low when `ack_en` is 1 and released when it is 0.
- R9: After an accepted access, `acc_busy` stays 1 for `SPACE` cycles (default 6). Any access made while `acc_busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc | input | 1 | Data-register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Receive buffer contents |
| acc_busy | output | 1 | Access spacing window active |
| ser_en | input | 1 | Serial output enable |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| ack_en | input | 1 | Acknowledge received bytes |
| bus_busy | input | 1 | Bus owned between start and stop |
| start_done | input | 1 | Start condition finished strobe |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | Pull SDA low |
| scl_drive_low | output | 1 | Pull SCL low |
| pend | output | 1 | Byte completed and not yet serviced |
| lrb | output | 1 | Acknowledge bit sampled in transmit |

## Verification
A wrong bit counter or shift register shows up in the serial byte a bus-side monitor rebuilds from SCL rises. It is seen within one byte time, 18·HALF cycles. A pending flag or launch flag in the wrong state shows up as extra SCL rises during the hold, or as a missing byte. A receive buffer that is loaded in the wrong place shows up on the next host read, one access later. A wrong spacing counter is seen within `SPACE` cycles, because `acc_busy` is counted and a write made during the window must not appear on the bus.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int HALF  = 4,
  parameter int SPACE = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       acc_wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       acc_busy,
  input  logic       ser_en,
  input  logic       rx_mode,
  input  logic       ack_en,
  input  logic       bus_busy,
  input  logic       start_done,
  input  logic       sda_in,
  output logic       sda_drive_low,
  output logic       scl_drive_low,
  output logic       pend,
  output logic       lrb
);
  localparam int DW = $clog2(HALF + 1);
  localparam int SW = $clog2(SPACE + 1);

  logic [7:0]    shreg, rbuf;
  logic [3:0]    bitcnt;
  logic [DW-1:0] div;
  logic [SW-1:0] gap;
  logic          hi, active, started, kick, pend_q, lrb_q;

  wire take   = acc && (gap == '0);
  wire tick   = active && (div == '0);
  wire launch = !active && started && bus_busy && ser_en && kick;
  wire ackbit = (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      rbuf    <= '0;
      bitcnt  <= '0;
      div     <= '0;
      gap     <= '0;
      hi      <= 1'b0;
      active  <= 1'b0;
      started <= 1'b0;
      kick    <= 1'b0;
      pend_q  <= 1'b0;
      lrb_q   <= 1'b0;
    end else begin
      if (take)             gap <= SW'(SPACE);
      else if (gap != '0)   gap <= gap - 1'b1;

      if (!bus_busy)        started <= 1'b0;
      else if (start_done)  started <= 1'b1;

      if (!bus_busy) begin
        active <= 1'b0;
        hi     <= 1'b0;
        bitcnt <= '0;
      end else if (launch) begin
        active <= 1'b1;
        hi     <= 1'b0;
        bitcnt <= '0;
        div    <= DW'(HALF - 1);
      end else if (tick) begin
        div <= DW'(HALF - 1);
        if (!hi) begin
          hi <= 1'b1;
          if (ackbit) begin
            if (!rx_mode) lrb_q <= sda_in;
          end else if (rx_mode) begin
            shreg <= {shreg[6:0], sda_in};
          end
        end else begin
          hi <= 1'b0;
          if (ackbit) begin
            active <= 1'b0;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 4'd1;
            if (!rx_mode) shreg <= {shreg[6:0], 1'b0};
            if (bitcnt == 4'd7 && rx_mode) rbuf <= shreg;
          end
        end
      end else if (active) begin
        div <= div - 1'b1;
      end

      if (take && acc_wr) shreg <= wdata;

      if (take && (acc_wr ^ rx_mode)) kick <= 1'b1;
      else if (launch)                kick <= 1'b0;

      if (tick && hi && bitcnt == 4'd7) pend_q <= 1'b1;
      else if (take)                    pend_q <= 1'b0;
    end
  end

  assign rdata         = rbuf;
  assign acc_busy      = (gap != '0);
  assign pend          = pend_q;
  assign lrb           = lrb_q;
  assign scl_drive_low = started && !(active && hi);
  assign sda_drive_low = active && (ackbit ? (rx_mode && ack_en) : (!rx_mode && !shreg[7]));
endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc,
  input logic       acc_busy,
  input logic       rx_mode,
  input logic       ser_en,
  input logic       bus_busy,
  input logic       sda_drive_low,
  input logic       scl_drive_low,
  input logic       pend,
  input logic       active,
  input logic [7:0] shreg
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_drive_low && !scl_drive_low && !pend && !acc_busy));

  assert_sda_changes_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_drive_low) && $past(bus_busy)) |-> scl_drive_low);

  assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (!ser_en && !active) |=> !active);

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && pend && !active) |=> !active);

  assert_busy_after_access_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && !acc_busy) |=> acc_busy);

  assert_busy_access_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && acc_busy && !active) |=> ($stable(shreg) && $stable(pend)));
endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk u_chk (
  .clk(clk), .rst(rst), .acc(acc), .acc_busy(acc_busy), .rx_mode(rx_mode),
  .ser_en(ser_en), .bus_busy(bus_busy), .sda_drive_low(sda_drive_low),
  .scl_drive_low(scl_drive_low), .pend(pend), .active(active), .shreg(shreg)
);

// File: tb/i2c_byte_shifter_tb.sv
module i2c_byte_shifter_tb;
  localparam int HALF  = 4;
  localparam int SPACE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc = 1'b0, acc_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic acc_busy, ser_en = 1'b0, rx_mode = 1'b0, ack_en = 1'b1;
  logic bus_busy = 1'b0, start_done = 1'b0;
  logic sda_drive_low, scl_drive_low, pend, lrb;
  logic nack = 1'b0;
  logic sda_slave, line;

  int tests = 0, fails = 0;
  int b = 0, ri = 0, rise_cnt = 0;
  bit seen_rise = 0, prev_scl = 1;
  logic [7:0] col = '0;
  logic [7:0] slv [4] = '{8'h5A, 8'hC3, 8'h0F, 8'h00};
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  assign sda_slave = rx_mode ? ((b < 8) ? slv[ri][7-b] : 1'b1)
                             : ((b == 8) ? nack : 1'b1);
  assign line = !sda_drive_low && sda_slave;

  i2c_byte_shifter #(.HALF(HALF), .SPACE(SPACE)) u_dut (
    .clk(clk), .rst(rst), .acc(acc), .acc_wr(acc_wr), .wdata(wdata),
    .rdata(rdata), .acc_busy(acc_busy), .ser_en(ser_en), .rx_mode(rx_mode),
    .ack_en(ack_en), .bus_busy(bus_busy), .start_done(start_done),
    .sda_in(line), .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low), .pend(pend), .lrb(lrb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Monitor: rebuilds bytes from SCL rises and compares with the scoreboard.
  always @(negedge clk) begin
    logic scl;
    scl = !scl_drive_low;
    if (!rst) begin
      if (scl && !prev_scl) begin
        rise_cnt++;
        seen_rise = 1;
        if (b < 8) col = {col[6:0], line};
        else if (!rx_mode) begin
          if (exp_q.size() == 0) chk(0, "R2 unexpected byte", col, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(col == e, "R2 serial byte", col, e);
          end
        end else begin
          chk(sda_drive_low == ack_en, "R8 ack drive", sda_drive_low, ack_en);
        end
      end else if (!scl && prev_scl && seen_rise) begin
        seen_rise = 0;
        if (b == 8) begin
          b = 0;
          if (rx_mode) ri++;
        end else b++;
      end
    end
    prev_scl = scl;
  end

  task automatic wait_idle();
    while (acc_busy) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    wait_idle();
    acc = 1'b1; acc_wr = 1'b1; wdata = d;
    exp_q.push_back(d);
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] d);
    wait_idle();
    acc = 1'b1; acc_wr = 1'b0;
    d = rdata;
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic wait_pend();
    int n = 0;
    while (!pend && n < 3000) begin @(negedge clk); n++; end
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int r0, busy_n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!sda_drive_low, "R1 sda released", sda_drive_low, 0);
    chk(!scl_drive_low, "R1 scl released", scl_drive_low, 0);
    chk(!pend && !acc_busy, "R1 flags clear", {pend, acc_busy}, 0);
    chk(rdata == 8'h00, "R1 buffer clear", rdata, 0);

    bus_busy = 1'b1;
    @(negedge clk); start_done = 1'b1;
    @(negedge clk); start_done = 1'b0;
    chk(scl_drive_low, "R3 scl low after start", scl_drive_low, 1);

    // write with serial output disabled, plus a write inside the busy window
    acc = 1'b1; acc_wr = 1'b1; wdata = 8'hA5; exp_q.push_back(8'hA5);
    @(negedge clk); wdata = 8'h00;
    @(negedge clk); acc = 1'b0;
    busy_n = 0;
    while (acc_busy && busy_n < 50) begin busy_n++; @(negedge clk); end
    chk(busy_n == SPACE - 1, "R9 busy window", busy_n, SPACE - 1);
    repeat (60) @(negedge clk);
    chk(rise_cnt == 0, "R3 no clock while disabled", rise_cnt, 0);

    ser_en = 1'b1;
    wait_pend();
    chk(lrb == 1'b0, "R4 ack captured", lrb, 0);
    r0 = rise_cnt;
    repeat (60) @(negedge clk);
    chk(rise_cnt == r0 && scl_drive_low, "R7 tx hold", rise_cnt, r0);

    nack = 1'b1;
    host_write(8'h3C);
    wait_pend();
    chk(lrb == 1'b1, "R4 nack captured", lrb, 1);
    nack = 1'b0;
    host_write(8'h81);
    wait_pend();
    chk(lrb == 1'b0, "R4 ack after nack", lrb, 0);
    chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);

    // receive
    rx_mode = 1'b1;
    host_read(rd);
    chk(rd == 8'h00, "R5 dummy read stale", rd, 8'h00);
    wait_pend();
    chk(rdata == 8'h5A, "R6 first byte buffered", rdata, 8'h5A);
    r0 = rise_cnt;
    repeat (60) @(negedge clk);
    chk(rise_cnt == r0 && scl_drive_low, "R7 rx hold", rise_cnt, r0);
    ack_en = 1'b0;
    host_read(rd);
    chk(rd == 8'h5A, "R5 read returns first byte", rd, 8'h5A);
    wait_pend();
    host_write(8'h77);
    void'(exp_q.pop_back());
    repeat (60) @(negedge clk);
    chk(rdata == 8'hC3, "R5 write does not alter buffer", rdata, 8'hC3);
    chk(!pend, "R7 access clears pend", pend, 0);
    ack_en = 1'b1;
    host_read(rd);
    chk(rd == 8'hC3, "R5 read returns second byte", rd, 8'hC3);
    wait_pend();
    chk(rdata == 8'h0F, "R6 third byte buffered", rdata, 8'h0F);
    chk(ri == 3, "R7 byte count", ri, 3);
    finish_run();
  end
endmodule